// File: doc/BRIEF.md
# Halving Parallel Sum Reducer

This block folds a bank of partial sums into one total by running halving rounds. Software or upstream logic first fills the bank through a simple indexed write port. A start pulse then runs the reduction. In each round, every lane below the new half count adds in the element that sits half positions above it. The rounds repeat until a single element remains. Lane zero then holds the total, which appears on the result output while done pulses.

The lane count is a parameter and need not be a power of two. When the remaining count is odd, lane zero first absorbs the unpaired top element and the count is then halved, so every lane count reduces correctly. Each round is a barrier step that takes one clock cycle. All updates in a round are computed from the values held when the round began. The accumulator is wide enough that the total of a full bank of maximum inputs never wraps.

Top module: `halving_sum_reducer`

## Requirements
- R1: After reset, busy and done are low and result is zero, because every bank element clears to zero.
- R2: While the block is idle, a cycle with load_en high writes load_data, zero-extended, into the element selected by load_idx. An index of N_LANES or above writes nothing. The value in element 0 shows on result from the next cycle.
- R3: A start sampled while idle raises busy in the next cycle. One halving round then runs per cycle. Done rises exactly one cycle after the last round, and the number of rounds is the number of integer halvings that take N_LANES down to 1 (3 for 10 lanes).
- R4: In a round whose half count is odd, element 0 adds element half-1 before the pairwise adds. Odd lane counts, and odd intermediate counts such as 5 when starting from 10, therefore still sum every element.
- R5: In the done cycle, result equals the exact sum of all N_LANES loaded values. Its width is IN_W plus ceil(log2 N_LANES) bits, so no total of maximum inputs overflows.
- R6: Done is high for exactly one cycle, and busy is low in that cycle.
- R7: A start that arrives while busy is ignored. The reduction neither restarts nor takes longer, and busy stays low after done.
- R8: A load that arrives while busy is ignored, and the total is unaffected.
- R9: A load in the same cycle as an accepted start is written before the first round and is included in the total.
- R10: With N_LANES equal to 1, a start gives done in the next cycle, busy never rises, and result is element 0 unchanged.
- R11: After done, result holds its value until element 0 is written again or a new reduction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one bank element |
| load_idx | input | IDX_W | Element index for the write |
| load_data | input | IN_W | Partial sum to store |
| start | input | 1 | Begin a reduction |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the total is ready |
| result | output | ACC_W | Content of element 0 |

## Verification
Start and load can arrive together, and the bench drives both on the same edge. It expects the written value to be in the total, because the write lands before the first round. A start or load held high through the busy cycles also meets the round logic in the same cycle. The bench judges this by the done latency and by the total, which must match a sum computed without the blocked write. Random banks from a fixed seed complete the comparison against a bench-side summing function.

// File: rtl/sumred_pkg.sv
package sumred_pkg;

   // Count of integer halvings needed to bring n down to 1.
   function automatic int unsigned halvings(input int unsigned n);
      int unsigned h;
      int unsigned c;
      h = n;
      c = 0;
      while (h > 1) begin
         h = h / 2;
         c = c + 1;
      end
      return c;
   endfunction

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sumred_round.sv
module sumred_round #(
   parameter int N      = 10,
   parameter int ACC_W  = 20,
   parameter int HALF_W = 4
) (
   input  logic [ACC_W-1:0]  cur [N],
   input  logic [HALF_W-1:0] half,
   output logic [ACC_W-1:0]  nxt [N]
);

   logic [HALF_W-1:0] new_half;
   logic [ACC_W-1:0]  orphan;
   logic [ACC_W-1:0]  lane0_base;

   assign new_half = half >> 1;

   // Unpaired top element when the count is odd.
   always_comb begin
      orphan = '0;
      for (int j = 0; j < N; j++) begin
         if ((j + 1) == int'(half)) orphan = cur[j];
      end
   end

   assign lane0_base = half[0] ? (cur[0] + orphan) : cur[0];

   for (genvar g = 0; g < N; g++) begin : g_lane
      logic [ACC_W-1:0] base;
      logic [ACC_W-1:0] partner;

      if (g == 0) begin : g_head
         assign base = lane0_base;
      end else begin : g_body
         assign base = cur[g];
      end

      always_comb begin
         partner = '0;
         for (int j = 0; j < N; j++) begin
            if (j == g + int'(new_half)) partner = cur[j];
         end
      end

      assign nxt[g] = (g < int'(new_half)) ? (base + partner) : base;
   end

endmodule

// File: rtl/sumred_bank.sv
module sumred_bank #(
   parameter int N     = 10,
   parameter int IN_W  = 16,
   parameter int ACC_W = 20,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IN_W-1:0]  wr_data,
   input  logic             upd_en,
   input  logic [ACC_W-1:0] upd_vals [N],
   output logic [ACC_W-1:0] vals [N]
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) vals[i] <= '0;
      end else if (upd_en) begin
         for (int i = 0; i < N; i++) vals[i] <= upd_vals[i];
      end else if (wr_en) begin
         for (int i = 0; i < N; i++) begin
            if (wr_idx == IDX_W'(i)) vals[i] <= ACC_W'(wr_data);
         end
      end
   end

   AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !wr_en) |=> $stable(vals[0]))
      else $error("bank changed without write or round"); // R8

endmodule

// File: rtl/sumred_ctrl.sv
module sumred_ctrl #(
   parameter int N      = 10,
   parameter int HALF_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [HALF_W-1:0] half
);
   import sumred_pkg::*;

   localparam int unsigned ROUNDS = halvings(N);

   if (N == 1) begin : g_single
      assign busy = 1'b0;
      assign half = HALF_W'(1);

      always_ff @(posedge clk) begin
         if (!rst_n) done <= 1'b0;
         else        done <= start;
      end

      AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> $past(start))
         else $error("single lane done without start"); // R10

   end else begin : g_multi
      logic [5:0] rnd_cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            half    <= '0;
            rnd_cnt <= '0;
         end else begin
            done <= 1'b0;
            if (!busy && start) begin
               busy    <= 1'b1;
               half    <= HALF_W'(N);
               rnd_cnt <= '0;
            end else if (busy) begin
               half    <= half >> 1;
               rnd_cnt <= rnd_cnt + 6'd1;
               if ((half >> 1) == HALF_W'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end

      AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         done |=> !done)
         else $error("done longer than one cycle"); // R6

      AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> (!busy && $past(busy)))
         else $error("done not at end of busy"); // R6

      AST_HALF_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
         busy |=> (half < $past(half)))
         else $error("half did not shrink"); // R3

      AST_ROUND_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> (rnd_cnt == 6'(ROUNDS)))
         else $error("wrong number of rounds"); // R3

      AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && start) |=> (half != HALF_W'(N)))
         else $error("start accepted while busy"); // R7
   end

endmodule

// File: rtl/halving_sum_reducer.sv
module halving_sum_reducer #(
   parameter int N_LANES = 10,
   parameter int IN_W    = 16,
   parameter int ACC_W   = IN_W + $clog2(N_LANES),
   parameter int IDX_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [IDX_W-1:0] load_idx,
   input  logic [IN_W-1:0]  load_data,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [ACC_W-1:0] result
);

   localparam int HALF_W = $clog2(N_LANES + 1);

   initial begin
      AST_PARAMS_OK: assert (N_LANES >= 1 && IN_W >= 1 &&
                             ACC_W >= IN_W + $clog2(N_LANES))
         else $error("bad parameters"); // R5
   end

   logic [HALF_W-1:0] half;
   logic [ACC_W-1:0]  bank [N_LANES];
   logic [ACC_W-1:0]  next_bank [N_LANES];

   sumred_ctrl #(.N(N_LANES), .HALF_W(HALF_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .half  (half)
   );

   sumred_round #(.N(N_LANES), .ACC_W(ACC_W), .HALF_W(HALF_W)) u_round (
      .cur  (bank),
      .half (half),
      .nxt  (next_bank)
   );

   sumred_bank #(.N(N_LANES), .IN_W(IN_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (load_en && !busy),
      .wr_idx   (load_idx),
      .wr_data  (load_data),
      .upd_en   (busy),
      .upd_vals (next_bank),
      .vals     (bank)
   );

   assign result = bank[0];

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_en) |=> $stable(result))
      else $error("result moved while idle"); // R11

endmodule

// File: tb/test_halving_sum_reducer.sv
`timescale 1ns/1ps
module test_halving_sum_reducer;
   localparam int N      = 10;
   localparam int IN_W   = 16;
   localparam int ACC_W  = IN_W + $clog2(N);
   localparam int IDX_W  = $clog2(N);
   localparam int ROUNDS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic             load_en = 1'b0;
   logic [IDX_W-1:0] load_idx = '0;
   logic [IN_W-1:0]  load_data = '0;
   logic             start = 1'b0;
   logic             busy, done;
   logic [ACC_W-1:0] result;

   logic             s_load_en = 1'b0;
   logic [0:0]       s_load_idx = '0;
   logic [IN_W-1:0]  s_load_data = '0;
   logic             s_start = 1'b0;
   logic             s_busy, s_done;
   logic [IN_W-1:0]  s_result;

   halving_sum_reducer #(.N_LANES(N), .IN_W(IN_W)) i_halving_sum_reducer (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
      .load_data(load_data), .start(start), .busy(busy), .done(done),
      .result(result));

   halving_sum_reducer #(.N_LANES(1), .IN_W(IN_W)) i_halving_sum_reducer_one (
      .clk(clk), .rst_n(rst_n), .load_en(s_load_en), .load_idx(s_load_idx),
      .load_data(s_load_data), .start(s_start), .busy(s_busy), .done(s_done),
      .result(s_result));

   int n_chk = 0;
   int n_fail = 0;
   int vals [N];

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint model_sum();
      longint s = 0;
      for (int i = 0; i < N; i++) s += vals[i];
      return s;
   endfunction

   task automatic write_one(input int idx, input int data);
      @(negedge clk);
      load_en = 1'b1; load_idx = IDX_W'(idx); load_data = IN_W'(data);
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic load_bank();
      for (int i = 0; i < N; i++) write_one(i, vals[i]);
   endtask

   // keep_start: hold start through busy; busy_load: write lane 0 while busy
   task automatic run_check(input string tag, input longint exp,
                            input bit keep_start, input bit busy_load);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk); #1;
      chk({tag, " R3 busy after start"}, busy, 1);
      start = keep_start;
      if (busy_load) begin
         load_en = 1'b1; load_idx = '0; load_data = '1;
      end
      for (int r = 1; r < ROUNDS; r++) begin
         @(posedge clk); #1;
         chk({tag, " R3 no early done"}, done, 0);
         chk({tag, " R3 busy mid"}, busy, 1);
      end
      start = 1'b0; load_en = 1'b0;
      @(posedge clk); #1;
      chk({tag, " R6 done on time"}, done, 1);
      chk({tag, " R6 busy low at done"}, busy, 0);
      chk({tag, " R5 total"}, result, exp);
      @(posedge clk); #1;
      chk({tag, " R6 done one cycle"}, done, 0);
      chk({tag, " R7 no restart"}, busy, 0);
      chk({tag, " R11 result held"}, result, exp);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 result", result, 0);

      // R2: write to lane 0 shows on result; out-of-range index ignored
      write_one(0, 16'h1234);
      chk("R2 lane0 write", result, 16'h1234);
      for (int i = 0; i < N; i++) vals[i] = i + 1;
      load_bank();
      write_one(12, 16'hFFFF);
      run_check("directed 1..N R4", model_sum(), 0, 0);

      // R5: all maximum values
      for (int i = 0; i < N; i++) vals[i] = 65535;
      load_bank();
      run_check("max R5", model_sum(), 0, 0);

      // R11: result held idle, then a lane-0 write replaces it
      repeat (4) @(posedge clk);
      #1 chk("R11 idle hold", result, model_sum());
      write_one(0, 7);
      chk("R11 lane0 rewrite", result, 7);

      // random banks
      for (int t = 0; t < 20; t++) begin
         for (int i = 0; i < N; i++) vals[i] = int'($urandom_range(65535, 0));
         load_bank();
         run_check("random R5", model_sum(), 0, 0);
      end

      // R7: start held high through busy
      for (int i = 0; i < N; i++) vals[i] = int'($urandom_range(65535, 0));
      load_bank();
      run_check("start while busy R7", model_sum(), 1, 0);

      // R8: write to lane 0 while busy is dropped
      for (int i = 0; i < N; i++) vals[i] = int'($urandom_range(1000, 0));
      load_bank();
      run_check("load while busy R8", model_sum(), 0, 1);

      // R9: load in the start cycle is included
      for (int i = 0; i < N; i++) vals[i] = 100 + i;
      load_bank();
      vals[N-1] = 5000;
      @(negedge clk);
      load_en = 1'b1; load_idx = IDX_W'(N-1); load_data = 16'd5000;
      start = 1'b1;
      @(posedge clk); #1;
      chk("R9 busy", busy, 1);
      start = 1'b0; load_en = 1'b0;
      repeat (ROUNDS) @(posedge clk);
      #1;
      chk("R9 done", done, 1);
      chk("R9 total with same-cycle load", result, model_sum());

      // R10: single-lane instance
      @(negedge clk);
      s_load_en = 1'b1; s_load_data = 16'd4321;
      @(negedge clk);
      s_load_en = 1'b0; s_start = 1'b1;
      @(posedge clk); #1;
      chk("R10 single busy", s_busy, 0);
      chk("R10 single done", s_done, 1);
      chk("R10 single result", s_result, 4321);
      s_start = 1'b0;
      @(posedge clk); #1;
      chk("R10 single done pulse", s_done, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule